// File: doc/BRIEF.md
# Bank Translation Unit for a Serially Loaded Cartridge Mapper

This block turns four 5-bit configuration values (a control word, two character bank words and a program bank word) into the physical bank numbers a cartridge board needs. It produces the bank numbers for two 16KB program ROM windows and two 4KB character memory windows. It also produces a two-bit nametable mirroring code and the controls for an 8KB work-RAM window: a chip enable, a bank bit and an open-bus flag. The logic that shifts the configuration words in serially sits outside this block. It presents the finished words on the inputs.

All outputs are registered, so a change on any input appears at the outputs one clock later. The control word picks a program layout: one 32KB region, a fixed first window, or a fixed last window. A character register bit adds an outer 256KB offset to every program bank. Parameters set the program and character bank widths, the number of banks actually fitted, whether 16KB of work RAM is present, and whether the RAM disable bit is honoured.

Top module: `cart_bank_xlate`

## Requirements
- R1: `mirror_mode` equals control bits 1:0, coded 0 single-screen lower, 1 single-screen upper, 2 vertical, 3 horizontal.
- R2: With control bit 4 at 1 (4KB character mode), `chr_lo_bank` is character word 0 and `chr_hi_bank` is character word 1.
- R3: With control bit 4 at 0 (8KB character mode), `chr_lo_bank` is character word 0 with bit 0 cleared, `chr_hi_bank` is the same value with bit 0 set, and character word 1 has no effect on either.
- R4: Program layout 3 (control bits 3:2 = 3): `prg_lo_bank` is program word bits 3:0 plus the outer offset, and `prg_hi_bank` is 15 plus the outer offset.
- R5: Program layout 2: `prg_lo_bank` is the outer offset alone, and `prg_hi_bank` is program word bits 3:0 plus the outer offset.
- R6: Program layouts 0 and 1: both windows come from program word bits 3:1 plus the outer offset, with bank bit 0 forced to 0 for the low window and to 1 for the high window.
- R7: The outer offset is 16 when character word 0 bit 4 is 1 and 0 otherwise, and it applies in every program layout.
- R8: Every program and character bank number is ANDed with the fitted bank count minus one (`PRG_BANKS`, `CHR_BANKS`, each a power of two).
- R9: Program word bit 4 at 1 disables work RAM unless `IGNORE_RAM_DIS` is 1. While disabled, an access in the RAM window gives `ram_ce` = 0, and a read (`ram_wr` = 0) gives `open_bus` = 1. While enabled, an access gives `ram_ce` = 1 and `open_bus` = 0. With no access, both are 0.
- R10: With `RAM_16K` = 1, `ram_bank` is character word 0 bit 4 in 4KB character mode and bit 3 in 8KB mode. With `RAM_16K` = 0 it is 0.
- R11: Outputs follow the inputs one clock later. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 5 | Control word: mirroring, program layout, character mode |
| chr0_word | input | 5 | Character bank word 0 |
| chr1_word | input | 5 | Character bank word 1 |
| prg_word | input | 5 | Program bank word, bit 4 is the RAM disable |
| ram_acc | input | 1 | CPU cycle targets the work-RAM window |
| ram_wr | input | 1 | 1 for a write, 0 for a read |
| prg_lo_bank | output | PRG_BANK_W | 16KB bank for the window at 0x8000 |
| prg_hi_bank | output | PRG_BANK_W | 16KB bank for the window at 0xC000 |
| chr_lo_bank | output | CHR_BANK_W | 4KB bank for the lower character window |
| chr_hi_bank | output | CHR_BANK_W | 4KB bank for the upper character window |
| mirror_mode | output | 2 | Nametable mirroring code |
| ram_ce | output | 1 | Work-RAM chip enable |
| ram_bank | output | 1 | 8KB work-RAM bank bit |
| open_bus | output | 1 | Read must return the last bus value |

## Verification
The bench builds two instances. The first uses the defaults: 32 program banks, 32 character banks, 16KB RAM, disable bit honoured. Here masking is the identity, and every layout and the outer offset are visible in full. The second fits only 8 banks of each kind, has 8KB RAM and ignores the disable bit. On this instance the masking of the outer offset, the constant zero RAM bank and the always-enabled RAM path can be observed. Both instances see the same random and directed words.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int unsigned WORD_W = 5;
  localparam logic [3:0] LAST_16K = 4'hF;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    PL_WIDE_A   = 2'd0,
    PL_WIDE_B   = 2'd1,
    PL_FIX_LOW  = 2'd2,
    PL_FIX_HIGH = 2'd3
  } prg_layout_e;
endpackage

// File: rtl/bank_prg_map.sv
module bank_prg_map
  import cart_bank_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 5,
  parameter int unsigned PRG_BANKS  = 32
) (
  input  logic [1:0]            layout,
  input  logic                  outer_sel,
  input  logic [3:0]            prg_sel,
  output logic [PRG_BANK_W-1:0] lo_bank,
  output logic [PRG_BANK_W-1:0] hi_bank
);
  localparam logic [PRG_BANK_W-1:0] BANK_MASK = PRG_BANK_W'(PRG_BANKS - 1);

  logic [WORD_W-1:0] offs, lo_raw, hi_raw;

  always_comb begin
    offs = {outer_sel, 4'b0000};
    unique case (prg_layout_e'(layout))
      PL_FIX_HIGH: begin
        lo_raw = offs | {1'b0, prg_sel};
        hi_raw = offs | {1'b0, LAST_16K};
      end
      PL_FIX_LOW: begin
        lo_raw = offs;
        hi_raw = offs | {1'b0, prg_sel};
      end
      default: begin
        lo_raw = offs | {1'b0, prg_sel[3:1], 1'b0};
        hi_raw = offs | {1'b0, prg_sel[3:1], 1'b1};
      end
    endcase
    lo_bank = PRG_BANK_W'(lo_raw) & BANK_MASK;
    hi_bank = PRG_BANK_W'(hi_raw) & BANK_MASK;
  end
endmodule

// File: rtl/bank_chr_map.sv
module bank_chr_map
  import cart_bank_pkg::*;
#(
  parameter int unsigned CHR_BANK_W = 5,
  parameter int unsigned CHR_BANKS  = 32
) (
  input  logic                  split_4k,
  input  logic [WORD_W-1:0]     chr0,
  input  logic [WORD_W-1:0]     chr1,
  output logic [CHR_BANK_W-1:0] lo_bank,
  output logic [CHR_BANK_W-1:0] hi_bank
);
  localparam logic [CHR_BANK_W-1:0] BANK_MASK = CHR_BANK_W'(CHR_BANKS - 1);

  logic [WORD_W-1:0] lo_raw, hi_raw;

  always_comb begin
    if (split_4k) begin
      lo_raw = chr0;
      hi_raw = chr1;
    end else begin
      lo_raw = {chr0[4:1], 1'b0};
      hi_raw = {chr0[4:1], 1'b1};
    end
    lo_bank = CHR_BANK_W'(lo_raw) & BANK_MASK;
    hi_bank = CHR_BANK_W'(hi_raw) & BANK_MASK;
  end
endmodule

// File: rtl/bank_ram_ctl.sv
module bank_ram_ctl #(
  parameter bit RAM_16K        = 1'b1,
  parameter bit IGNORE_RAM_DIS = 1'b0
) (
  input  logic split_4k,
  input  logic chr0_b4,
  input  logic chr0_b3,
  input  logic ram_dis,
  input  logic acc,
  input  logic wr,
  output logic ce,
  output logic open_bus,
  output logic bank
);
  logic enabled;

  always_comb begin
    enabled  = IGNORE_RAM_DIS ? 1'b1 : !ram_dis;
    ce       = acc && enabled;
    open_bus = acc && !wr && !enabled;
    bank     = RAM_16K ? (split_4k ? chr0_b4 : chr0_b3) : 1'b0;
  end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
  import cart_bank_pkg::*;
#(
  parameter int unsigned PRG_BANK_W     = 5,
  parameter int unsigned PRG_BANKS      = 32,
  parameter int unsigned CHR_BANK_W     = 5,
  parameter int unsigned CHR_BANKS      = 32,
  parameter bit          RAM_16K        = 1'b1,
  parameter bit          IGNORE_RAM_DIS = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4:0]            ctrl_word,
  input  logic [4:0]            chr0_word,
  input  logic [4:0]            chr1_word,
  input  logic [4:0]            prg_word,
  input  logic                  ram_acc,
  input  logic                  ram_wr,
  output logic [PRG_BANK_W-1:0] prg_lo_bank,
  output logic [PRG_BANK_W-1:0] prg_hi_bank,
  output logic [CHR_BANK_W-1:0] chr_lo_bank,
  output logic [CHR_BANK_W-1:0] chr_hi_bank,
  output logic [1:0]            mirror_mode,
  output logic                  ram_ce,
  output logic                  ram_bank,
  output logic                  open_bus
);
  localparam logic [PRG_BANK_W-1:0] PRG_MASK = PRG_BANK_W'(PRG_BANKS - 1);

  logic [PRG_BANK_W-1:0] prg_lo_d, prg_hi_d;
  logic [CHR_BANK_W-1:0] chr_lo_d, chr_hi_d;
  logic [1:0]            mirror_d;
  logic                  ce_d, bank_d, ob_d;
  logic                  split_4k;

  assign split_4k = ctrl_word[4];

  bank_prg_map #(.PRG_BANK_W(PRG_BANK_W), .PRG_BANKS(PRG_BANKS)) u_prg (
    .layout    (ctrl_word[3:2]),
    .outer_sel (chr0_word[4]),
    .prg_sel   (prg_word[3:0]),
    .lo_bank   (prg_lo_d),
    .hi_bank   (prg_hi_d)
  );

  bank_chr_map #(.CHR_BANK_W(CHR_BANK_W), .CHR_BANKS(CHR_BANKS)) u_chr (
    .split_4k (split_4k),
    .chr0     (chr0_word),
    .chr1     (chr1_word),
    .lo_bank  (chr_lo_d),
    .hi_bank  (chr_hi_d)
  );

  bank_ram_ctl #(.RAM_16K(RAM_16K), .IGNORE_RAM_DIS(IGNORE_RAM_DIS)) u_ram (
    .split_4k (split_4k),
    .chr0_b4  (chr0_word[4]),
    .chr0_b3  (chr0_word[3]),
    .ram_dis  (prg_word[4]),
    .acc      (ram_acc),
    .wr       (ram_wr),
    .ce       (ce_d),
    .open_bus (ob_d),
    .bank     (bank_d)
  );

  always_comb mirror_d = mirror_e'(ctrl_word[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_lo_bank <= '0;
      prg_hi_bank <= '0;
      chr_lo_bank <= '0;
      chr_hi_bank <= '0;
      mirror_mode <= '0;
      ram_ce      <= 1'b0;
      ram_bank    <= 1'b0;
      open_bus    <= 1'b0;
    end else begin
      prg_lo_bank <= prg_lo_d;
      prg_hi_bank <= prg_hi_d;
      chr_lo_bank <= chr_lo_d;
      chr_hi_bank <= chr_hi_d;
      mirror_mode <= mirror_d;
      ram_ce      <= ce_d;
      ram_bank    <= bank_d;
      open_bus    <= ob_d;
    end
  end

  // R1
  mirror_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mirror_mode == $past(ctrl_word[1:0]));

  // R4
  fixed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[3:2] == 2'd3 |=>
      prg_hi_bank == (PRG_BANK_W'({$past(chr0_word[4]), 4'hF}) & PRG_MASK));

  // R5
  fixed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[3:2] == 2'd2 |=>
      prg_lo_bank == (PRG_BANK_W'({$past(chr0_word[4]), 4'h0}) & PRG_MASK));

  // R6
  wide_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[3] |=> (prg_hi_bank & ~PRG_BANK_W'(1)) == prg_lo_bank);

  // R9
  ram_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_ce && open_bus));

  // R9
  ram_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_word[4] && !IGNORE_RAM_DIS) |=> !ram_ce);

  // R3
  chr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[4] |=> (chr_hi_bank & ~CHR_BANK_W'(1)) == chr_lo_bank);
endmodule

// File: tb/tb_cart_bank_xlate.sv
module tb_cart_bank_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] ctrl_word = '0, chr0_word = '0, chr1_word = '0, prg_word = '0;
  logic ram_acc = 1'b0, ram_wr = 1'b0;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [4:0] a_plo, a_phi, a_clo, a_chi;
  logic [1:0] a_mir;
  logic a_ce, a_bank, a_ob;
  logic [2:0] b_plo, b_phi, b_clo, b_chi;
  logic [1:0] b_mir;
  logic b_ce, b_bank, b_ob;

  always #10 clk = ~clk;

  cart_bank_xlate dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .chr0_word(chr0_word),
    .chr1_word(chr1_word), .prg_word(prg_word), .ram_acc(ram_acc), .ram_wr(ram_wr),
    .prg_lo_bank(a_plo), .prg_hi_bank(a_phi), .chr_lo_bank(a_clo), .chr_hi_bank(a_chi),
    .mirror_mode(a_mir), .ram_ce(a_ce), .ram_bank(a_bank), .open_bus(a_ob));

  cart_bank_xlate #(.PRG_BANK_W(3), .PRG_BANKS(8), .CHR_BANK_W(3), .CHR_BANKS(8),
                    .RAM_16K(1'b0), .IGNORE_RAM_DIS(1'b1)) dut_small (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .chr0_word(chr0_word),
    .chr1_word(chr1_word), .prg_word(prg_word), .ram_acc(ram_acc), .ram_wr(ram_wr),
    .prg_lo_bank(b_plo), .prg_hi_bank(b_phi), .chr_lo_bank(b_clo), .chr_hi_bank(b_chi),
    .mirror_mode(b_mir), .ram_ce(b_ce), .ram_bank(b_bank), .open_bus(b_ob));

  function automatic logic [4:0] exp_prg(input logic [4:0] c, c0, p, input bit hi);
    logic [4:0] o;
    o = {c0[4], 4'b0};
    case (c[3:2])
      2'd3: return hi ? (o | 5'h0F) : (o | {1'b0, p[3:0]});
      2'd2: return hi ? (o | {1'b0, p[3:0]}) : o;
      default: return o | {1'b0, p[3:1], hi};
    endcase
  endfunction

  function automatic logic [4:0] exp_chr(input logic [4:0] c, c0, c1, input bit hi);
    if (c[4]) return hi ? c1 : c0;
    return {c0[4:1], hi};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit en_a;
    en_a = !prg_word[4];
    chk("R1", "mirror", int'(a_mir), int'(ctrl_word[1:0]));
    chk("R4/R5/R6/R7", "prg lo", int'(a_plo), int'(exp_prg(ctrl_word, chr0_word, prg_word, 1'b0)));
    chk("R4/R5/R6/R7", "prg hi", int'(a_phi), int'(exp_prg(ctrl_word, chr0_word, prg_word, 1'b1)));
    chk("R2/R3", "chr lo", int'(a_clo), int'(exp_chr(ctrl_word, chr0_word, chr1_word, 1'b0)));
    chk("R2/R3", "chr hi", int'(a_chi), int'(exp_chr(ctrl_word, chr0_word, chr1_word, 1'b1)));
    chk("R9", "ce", int'(a_ce), int'(ram_acc && en_a));
    chk("R9", "open bus", int'(a_ob), int'(ram_acc && !ram_wr && !en_a));
    chk("R10", "ram bank", int'(a_bank), int'(ctrl_word[4] ? chr0_word[4] : chr0_word[3]));
    chk("R8", "small prg lo", int'(b_plo), int'(exp_prg(ctrl_word, chr0_word, prg_word, 1'b0) & 5'd7));
    chk("R8", "small prg hi", int'(b_phi), int'(exp_prg(ctrl_word, chr0_word, prg_word, 1'b1) & 5'd7));
    chk("R8", "small chr lo", int'(b_clo), int'(exp_chr(ctrl_word, chr0_word, chr1_word, 1'b0) & 5'd7));
    chk("R8", "small chr hi", int'(b_chi), int'(exp_chr(ctrl_word, chr0_word, chr1_word, 1'b1) & 5'd7));
    chk("R9", "small ce ignores disable", int'(b_ce), int'(ram_acc));
    chk("R9", "small open bus", int'(b_ob), 0);
    chk("R10", "small ram bank", int'(b_bank), 0);
  endtask

  task automatic apply(input logic [4:0] c, c0, c1, p, input logic acc, wr);
    @(negedge clk);
    ctrl_word = c; chr0_word = c0; chr1_word = c1; prg_word = p;
    ram_acc = acc; ram_wr = wr;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    ctrl_word = 5'h1F; chr0_word = 5'h1F; chr1_word = 5'h1F; prg_word = 5'h0F;
    ram_acc = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset holds every output at 0
    chk("R11", "reset prg", int'({a_plo, a_phi, b_plo, b_phi}), 0);
    chk("R11", "reset chr", int'({a_clo, a_chi, b_clo, b_chi}), 0);
    chk("R11", "reset misc", int'({a_mir, a_ce, a_bank, a_ob, b_mir, b_ce}), 0);
    rst_n = 1'b1;
    // R11: one-cycle latency, before the edge outputs still hold old value
    @(negedge clk);
    ctrl_word = 5'h02;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R11", "latency", int'(a_mir), 2);
    // R1 all mirror codes
    for (int m = 0; m < 4; m++) apply(5'(m) | 5'h1C, 5'h03, 5'h09, 5'h05, 1'b0, 1'b0);
    // R4 fixed last, outer offset on and off (R7)
    apply(5'h0C, 5'h00, 5'h00, 5'h06, 1'b0, 1'b0);
    chk("R4", "fixed last", int'(a_phi), 15);
    apply(5'h0C, 5'h10, 5'h00, 5'h06, 1'b0, 1'b0);
    chk("R7", "outer on fixed last", int'(a_phi), 31);
    // R5 fixed first
    apply(5'h08, 5'h10, 5'h00, 5'h0B, 1'b0, 1'b0);
    chk("R5", "fixed first", int'(a_plo), 16);
    chk("R8", "outer masked away", int'(b_plo), 0);
    // R6 wide mode with odd program value
    apply(5'h04, 5'h00, 5'h00, 5'h07, 1'b0, 1'b0);
    chk("R6", "wide lo even", int'(a_plo), 6);
    chk("R6", "wide hi odd", int'(a_phi), 7);
    // R3 8KB mode, character word 1 has no effect
    apply(5'h00, 5'h0B, 5'h15, 5'h00, 1'b0, 1'b0);
    chk("R3", "8k lo", int'(a_clo), 10);
    apply(5'h00, 5'h0B, 5'h02, 5'h00, 1'b0, 1'b0);
    chk("R3", "8k hi independent of word 1", int'(a_chi), 11);
    // R2 4KB mode
    apply(5'h10, 5'h0B, 5'h15, 5'h00, 1'b0, 1'b0);
    chk("R2", "4k hi", int'(a_chi), 21);
    // R9 disabled read, disabled write, enabled read
    apply(5'h00, 5'h00, 5'h00, 5'h10, 1'b1, 1'b0);
    chk("R9", "disabled read open bus", int'(a_ob), 1);
    apply(5'h00, 5'h00, 5'h00, 5'h10, 1'b1, 1'b1);
    chk("R9", "disabled write dropped", int'(a_ce), 0);
    apply(5'h00, 5'h00, 5'h00, 5'h00, 1'b1, 1'b0);
    chk("R9", "enabled read", int'(a_ce), 1);
    // R10 bank bit source per character mode
    apply(5'h10, 5'h10, 5'h00, 5'h00, 1'b1, 1'b0);
    chk("R10", "4k mode bit 4", int'(a_bank), 1);
    apply(5'h00, 5'h10, 5'h00, 5'h00, 1'b1, 1'b0);
    chk("R10", "8k mode bit 3", int'(a_bank), 0);
    // random sweep
    for (int i = 0; i < 400; i++)
      apply(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom),
            1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule